// File: doc/BRIEF.md
# Windowed watchdog timer

A down-counting supervision timer for a system-on-chip. A configuration word captured while reset is held selects the timeout length, the divide ratio of the count clock, which quarters of each period accept a refresh, whether a fault raises an interrupt or a reset request, whether counting starts by itself, and whether counting pauses while the system sleeps.

Software refreshes the timer by writing two key values in a row on a write port. A refresh that lands in a quarter of the period that the mask does not allow is a refresh error. Running down to zero is an underflow. Either fault raises the same event: a one-cycle interrupt pulse in interrupt mode, or a reset request that stays high until the block is reset. Sticky status flags record which fault happened. The write port uses valid/ready. Ready is always high, so the port never applies back-pressure, and a write counts on every cycle in which valid is high.

Top module: `window_watchdog`

## Requirements
- R1: The configuration is captured on every clock edge with `rst_n` low. If bit 0 is 0, counting starts at the first edge after reset. If bit 0 is 1, the counter holds, with `running_o` low and no event, until the first completed key sequence. That sequence sets `running_o` and reloads the counter. `running_o` never drops again before reset.
- R2: Bits 3:2 pick the period P: 0→256, 1→4096, 2→16384, 3→65536 count ticks. With divide-by-1 and auto-start, the first underflow event appears after clock edge P, counting from the first edge after reset.
- R3: Bits 7:4 pick the divide ratio 2^code. The default variant accepts codes 0, 4, 5, 6, 7, 8 and 11. The alternate variant (`ALT_DIV=1`) accepts codes 2, 6, 7, 8, 9, 10, 11 and 13. Any other code uses the smallest ratio of its variant. With code 4, the first underflow comes after edge 16·P.
- R4: A refresh is an accepted write of 0x0123 followed directly by an accepted write of 0x3210. Any other second write cancels the sequence and leaves the counter untouched. A 0x3210 that does not follow 0x0123 does nothing.
- R5: Bits 11:8 are a quarter mask. Bit 8+q allows refresh in quarter q = floor(4·elapsed/P), where elapsed = P−1−count. A mask of 0000 allows every quarter. A refresh in a quarter that is not allowed sets the refresh-error flag, raises the event and does not reload the counter.
- R6: Bit 1 = 0 selects interrupt mode. Each event gives a one-cycle `irq_o` pulse, and an underflow reloads the counter. Bit 1 = 1 selects reset mode. An event raises `rst_req_o`, which stays high until reset while the counter freezes, and `irq_o` never pulses.
- R7: With bit 12 = 1, the prescaler and the counter hold on every edge at which `sleep_i` is high. With bit 12 = 0, `sleep_i` has no effect.
- R8: `flag_underflow_o` and `flag_referr_o` are sticky. Bit 0 of `flag_clr_i` clears the underflow flag and bit 1 clears the refresh-error flag. If a flag is set and cleared at the same edge, the set wins.
- R9: A valid refresh reloads the counter to P−1 and restarts the prescaler phase, so the next underflow comes P·ratio edges after the edge of the second key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the configuration is captured while it is low |
| sleep_i | input | 1 | System sleep indicator |
| cfg_i | input | 16 | Configuration word (bit fields as in R1–R7) |
| wr_valid_i | input | 1 | Refresh write valid |
| wr_ready_o | output | 1 | Refresh write ready, constantly high |
| wr_data_i | input | DATA_W | Refresh write data |
| flag_clr_i | input | 2 | Write-one-to-clear for the two flags (bit 0 underflow, bit 1 refresh error) |
| running_o | output | 1 | Counter has been started |
| flag_underflow_o | output | 1 | Sticky underflow flag |
| flag_referr_o | output | 1 | Sticky refresh-error flag |
| irq_o | output | 1 | One-cycle event pulse in interrupt mode |
| rst_req_o | output | 1 | Held reset request in reset mode |

## Verification
A count that is off by one, or a prescaler phase that is not restarted, moves the first event edge. That edge can be predicted exactly from reset or from the last refresh, so the shift is visible within one period. A wrong quarter decode or a key state left half-armed shows up at the next refresh attempt, as a spurious or missing error flag and event. A wrong pause or freeze decision shows up as an event edge that drifts from a cycle-by-cycle reference model, which compares the event outputs and flags on every cycle.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  // Configuration fields kept after reset (the start bit only matters at reset)
  typedef struct packed {
    logic       slp_hold;
    logic [3:0] win_mask;
    logic [3:0] div_code;
    logic [1:0] per_code;
    logic       evt_reset;
  } wwdt_set_t;

  // log2 of the divide ratio; unknown codes fall back to the smallest ratio
  function automatic logic [3:0] div_shift(input logic [3:0] code, input logic alt_set);
    logic [3:0] s;
    if (!alt_set) begin
      case (code)
        4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd11: s = code;
        default: s = 4'd0;
      endcase
    end else begin
      case (code)
        4'd2, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd13: s = code;
        default: s = 4'd2;
      endcase
    end
    return s;
  endfunction

  // log2 of the period length
  function automatic logic [4:0] per_shift(input logic [1:0] code);
    logic [4:0] s;
    case (code)
      2'd0: s = 5'd8;
      2'd1: s = 5'd12;
      2'd2: s = 5'd14;
      default: s = 5'd16;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wwdt_prescale.sv
module wwdt_prescale #(
  parameter int PRE_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [3:0] shift,
  output logic       tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] last;

  assign last = ~({PRE_W{1'b1}} << shift);
  assign tick = en && (phase_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else if (en)           phase_q <= tick ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/wwdt_keyseq.sv
module wwdt_keyseq #(
  parameter int          DATA_W   = 16,
  parameter logic [15:0] KEY_ARM  = 16'h0123,
  parameter logic [15:0] KEY_FIRE = 16'h3210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fire
);
  logic armed_q;

  assign fire = wr_valid && armed_q && (wr_data == DATA_W'(KEY_FIRE));

  // any write after arming consumes the armed state, matching or not
  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (wr_valid) armed_q <= !armed_q && (wr_data == DATA_W'(KEY_ARM));
  end
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] span,
  input  logic [4:0]       per_sh,
  input  logic [3:0]       mask,
  output logic             open
);
  logic [CNT_W-1:0] elapsed;
  logic [1:0]       quarter;

  assign elapsed = span - count;
  assign quarter = 2'(elapsed >> (per_sh - 5'd2));
  assign open    = (mask == 4'b0000) || mask[quarter];
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwdt_pkg::*;
#(
  parameter int          CNT_W    = 16,
  parameter int          PRE_W    = 13,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] KEY_ARM  = 16'h0123,
  parameter logic [15:0] KEY_FIRE = 16'h3210,
  parameter logic        ALT_DIV  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic [15:0]       cfg_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        flag_clr_i,
  output logic              running_o,
  output logic              flag_underflow_o,
  output logic              flag_referr_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int NFLAG = 2;

  wwdt_set_t        cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             irq_q;
  logic             rst_req_q;
  logic [NFLAG-1:0] flag_q;

  logic [4:0]       per_sh;
  logic [3:0]       div_sh;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] span_at_rst;
  logic             en, tick, fire, open;
  logic             good_ref, bad_ref, uflow, evt, reload;
  logic [NFLAG-1:0] flag_set;
  logic             spare_unused;

  assign spare_unused = ^cfg_i[15:13];

  assign per_sh      = per_shift(cfg_q.per_code);
  assign div_sh      = div_shift(cfg_q.div_code, ALT_DIV);
  assign span        = ~({CNT_W{1'b1}} << per_sh);
  assign span_at_rst = ~({CNT_W{1'b1}} << per_shift(cfg_i[3:2]));

  // counting is paused by sleep (if configured) and frozen after a reset request
  assign en = run_q && !(cfg_q.slp_hold && sleep_i) && !rst_req_q;

  wwdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(reload), .shift(div_sh), .tick(tick)
  );

  wwdt_keyseq #(.DATA_W(DATA_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid_i), .wr_data(wr_data_i), .fire(fire)
  );

  wwdt_window #(.CNT_W(CNT_W)) u_win (
    .count(cnt_q), .span(span), .per_sh(per_sh), .mask(cfg_q.win_mask), .open(open)
  );

  // a refresh before the first start is always accepted
  assign good_ref = fire && !rst_req_q && (!run_q || open);
  assign bad_ref  = fire && !rst_req_q && run_q && !open;
  assign uflow    = tick && (cnt_q == '0) && !good_ref;
  assign evt      = uflow || bad_ref;
  assign reload   = good_ref || (uflow && !cfg_q.evt_reset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{slp_hold: cfg_i[12], win_mask: cfg_i[11:8], div_code: cfg_i[7:4],
                 per_code: cfg_i[3:2], evt_reset: cfg_i[1]};
      cnt_q <= span_at_rst;
      run_q <= !cfg_i[0];
    end else if (reload) begin
      cnt_q <= span;
      run_q <= 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      irq_q     <= evt && !cfg_q.evt_reset;
      rst_req_q <= rst_req_q || (evt && cfg_q.evt_reset);
    end
  end

  // sticky flags: index 0 underflow, index 1 refresh error; set beats clear
  assign flag_set = {bad_ref, uflow};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_set[i] || (flag_q[i] && !flag_clr_i[i]);
    end
  end

  assign wr_ready_o       = 1'b1;
  assign running_o        = run_q;
  assign flag_underflow_o = flag_q[0];
  assign flag_referr_o    = flag_q[1];
  assign irq_o            = irq_q;
  assign rst_req_o        = rst_req_q;
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             rst_req,
  input logic             flag_uf,
  input logic             flag_re,
  input logic             running,
  input logic             evt_reset,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] span
);
  // R6: interrupt is a single-cycle pulse
  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);

  // R6: reset request holds until reset
  a_r6_rst_hold: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req);

  // R6: reset mode never pulses the interrupt
  a_r6_no_irq_rst_mode: assert property (@(posedge clk) disable iff (!rst_n) evt_reset |-> !irq);

  // R8: every interrupt leaves a cause flag behind
  a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_uf || flag_re));

  // R1: once started the counter never returns to the stopped state
  a_r1_run_stays: assert property (@(posedge clk) disable iff (!rst_n) running |=> running);

  // R2: the count never exceeds the reload value of the selected period
  a_r2_cnt_in_span: assert property (@(posedge clk) disable iff (!rst_n) cnt <= span);
endmodule

bind window_watchdog wwdt_checker #(.CNT_W(CNT_W)) u_wwdt_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .rst_req(rst_req_o),
  .flag_uf(flag_underflow_o), .flag_re(flag_referr_o), .running(running_o),
  .evt_reset(cfg_q.evt_reset), .cnt(cnt_q), .span(span)
);

// File: tb/test_window_watchdog.sv
`timescale 1ns/1ps
module test_window_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_in = 1'b0;
  logic [15:0] cfg_in = 16'h0001;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  flag_clr = 2'b00;
  logic        wr_ready, running, f_uf, f_re, irq, rst_req;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  window_watchdog i_window_watchdog (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_in), .cfg_i(cfg_in),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .flag_clr_i(flag_clr), .running_o(running), .flag_underflow_o(f_uf),
    .flag_referr_o(f_re), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bper(input logic [1:0] c);
    case (c)
      2'd0: return 256;
      2'd1: return 4096;
      2'd2: return 16384;
      default: return 65536;
    endcase
  endfunction

  function automatic int bdiv(input logic [3:0] c);
    case (c)
      4'd4: return 16;
      4'd5: return 32;
      4'd6: return 64;
      4'd7: return 128;
      4'd8: return 256;
      4'd11: return 2048;
      default: return 1;
    endcase
  endfunction

  function automatic logic [15:0] mk(input bit hold, input bit rmode, input logic [1:0] per,
                                     input logic [3:0] dv, input logic [3:0] win, input bit slp);
    return {3'b000, slp, win, dv, per, rmode, hold};
  endfunction

  // reference model, stepped on each clock edge from the requirements
  logic [15:0] m_cfg;
  int  m_plen, m_ratio, m_pre, m_cnt, edge_no;
  bit  m_run, m_arm, m_uf, m_re, m_irq, m_rst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = cfg_in; m_plen = bper(cfg_in[3:2]); m_ratio = bdiv(cfg_in[7:4]);
      m_run = !cfg_in[0]; m_pre = 0; m_cnt = m_plen - 1; m_arm = 0;
      m_uf = 0; m_re = 0; m_irq = 0; m_rst = 0; edge_no = 0;
    end else begin
      bit fire, ok, act, tk, good, bad, und;
      int q;
      edge_no++;
      fire = wr_valid && m_arm && (wr_data == 16'h3210);
      if (wr_valid) m_arm = !m_arm && (wr_data == 16'h0123);
      q    = ((m_plen - 1 - m_cnt) * 4) / m_plen;
      ok   = (m_cfg[11:8] == 4'b0000) || m_cfg[8 + q];
      act  = m_run && !(m_cfg[12] && sleep_in) && !m_rst;
      tk   = act && (m_pre == m_ratio - 1);
      good = fire && !m_rst && (!m_run || ok);
      bad  = fire && !m_rst && m_run && !ok;
      und  = tk && (m_cnt == 0) && !good;
      m_uf = und || (m_uf && !flag_clr[0]);
      m_re = bad || (m_re && !flag_clr[1]);
      m_irq = (und || bad) && !m_cfg[1];
      if ((und || bad) && m_cfg[1]) m_rst = 1;
      if (good || (und && !m_cfg[1])) begin
        m_run = 1; m_cnt = m_plen - 1; m_pre = 0;
      end else if (act) begin
        m_pre = tk ? 0 : m_pre + 1;
        if (tk && m_cnt > 0) m_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 irq_o vs model", irq, m_irq);
      check("R6 rst_req_o vs model", rst_req, m_rst);
      check("R8 flag_underflow_o vs model", f_uf, m_uf);
      check("R5 flag_referr_o vs model", f_re, m_re);
      check("R1 running_o vs model", running, m_run);
    end
  end

  task automatic do_reset(input logic [15:0] c);
    @(negedge clk);
    rst_n = 0; cfg_in = c; wr_valid = 0; sleep_in = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // returns the edge number at which irq or rst_req is first seen
  task automatic run_dir(input logic [15:0] c, input int k1, input logic [15:0] k2,
                         input int s_from, input int s_to, input int limit,
                         output int first, output bit was_rst);
    do_reset(c);
    first = -1; was_rst = 0;
    for (int i = 0; i < limit && first < 0; i++) begin
      wr_valid = 0;
      if (i + 1 == k1)     begin wr_valid = 1; wr_data = 16'h0123; end
      if (i + 1 == k1 + 1) begin wr_valid = 1; wr_data = k2; end
      sleep_in = (i + 1 >= s_from) && (i + 1 <= s_to);
      @(negedge clk);
      if (irq || rst_req) begin first = edge_no; was_rst = rst_req; end
    end
    wr_valid = 0; sleep_in = 0;
  endtask

  initial begin
    int first;
    bit wr;
    void'($urandom(32'd20240611));

    // R1: reset state with the start held
    do_reset(mk(1, 0, 2'd0, 4'd0, 4'd0, 0));
    check("R1 running after reset", running, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 rst_req after reset", rst_req, 0);
    check("R1 flags after reset", {f_uf, f_re}, 0);
    check("R1 ready", wr_ready, 1);

    run_dir(mk(1, 0, 2'd0, 4'd0, 4'd0, 0), -10, 16'h3210, 0, -1, 700, first, wr);
    check("R1 held start gives no event", first, -1);
    check("R1 held start stays stopped", running, 0);

    run_dir(mk(1, 0, 2'd0, 4'd0, 4'd0, 0), 100, 16'h3210, 0, -1, 2000, first, wr);
    check("R1 key starts counter, event edge", first, 101 + 256);

    run_dir(mk(0, 0, 2'd0, 4'd0, 4'd0, 0), -10, 16'h3210, 0, -1, 2000, first, wr);
    check("R2 period 256 underflow edge", first, 256);
    @(negedge clk);
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    check("R8 underflow flag cleared by write-one", f_uf, 0);

    run_dir(mk(0, 0, 2'd1, 4'd0, 4'd0, 0), -10, 16'h3210, 0, -1, 6000, first, wr);
    check("R2 period 4096 underflow edge", first, 4096);

    run_dir(mk(0, 0, 2'd0, 4'd4, 4'd0, 0), -10, 16'h3210, 0, -1, 6000, first, wr);
    check("R3 divide by 16 underflow edge", first, 16 * 256);

    run_dir(mk(0, 0, 2'd0, 4'd3, 4'd0, 0), -10, 16'h3210, 0, -1, 2000, first, wr);
    check("R3 unlisted code uses smallest ratio", first, 256);

    run_dir(mk(0, 0, 2'd0, 4'd0, 4'd0, 0), 100, 16'h5555, 0, -1, 2000, first, wr);
    check("R4 wrong second key cancels, no reload", first, 256);

    run_dir(mk(0, 0, 2'd0, 4'd0, 4'd0, 0), 100, 16'h3210, 0, -1, 2000, first, wr);
    check("R9 refresh reloads counter", first, 101 + 256);

    run_dir(mk(0, 0, 2'd0, 4'd0, 4'b0001, 0), 199, 16'h3210, 0, -1, 2000, first, wr);
    check("R5 refresh in closed quarter gives event", first, 200);
    check("R5 refresh error flag set", f_re, 1);
    check("R5 underflow flag not set", f_uf, 0);

    run_dir(mk(0, 0, 2'd0, 4'd0, 4'b1000, 0), 199, 16'h3210, 0, -1, 2000, first, wr);
    check("R5 refresh in open last quarter", first, 200 + 256);

    run_dir(mk(0, 1, 2'd0, 4'd0, 4'd0, 0), -10, 16'h3210, 0, -1, 2000, first, wr);
    check("R6 reset mode event edge", first, 256);
    check("R6 reset mode uses rst_req", wr, 1);
    repeat (300) @(negedge clk);
    check("R6 rst_req held", rst_req, 1);
    check("R6 no irq in reset mode", irq, 0);

    run_dir(mk(0, 0, 2'd0, 4'd0, 4'd0, 1), -10, 16'h3210, 50, 149, 2000, first, wr);
    check("R7 sleep pauses counting", first, 256 + 100);

    run_dir(mk(0, 0, 2'd0, 4'd0, 4'd0, 0), -10, 16'h3210, 50, 149, 2000, first, wr);
    check("R7 sleep ignored when not configured", first, 256);

    // randomized configurations against the model (R1..R9)
    for (int n = 0; n < 12; n++) begin
      logic [1:0]  per;
      logic [3:0]  dv;
      logic [15:0] c;
      int rate;
      bit pend;
      per = ($urandom % 4 == 0) ? 2'd1 : 2'd0;
      case ($urandom % 5)
        0: dv = 4'd1;
        1: dv = 4'd4;
        2: dv = 4'd3;
        default: dv = 4'd0;
      endcase
      if (per != 0) dv = 4'd0;
      c = mk($urandom % 3 == 0, $urandom % 4 == 0, per, dv, 4'($urandom), 1'($urandom));
      c[15:13] = 3'($urandom);
      rate = (n % 3) * 2;
      pend = 0;
      do_reset(c);
      for (int k = 0; k < 3000; k++) begin
        int r;
        r = $urandom % 100;
        wr_valid = 0; flag_clr = 0;
        if (pend) begin
          wr_valid = 1; wr_data = (r < 85) ? 16'h3210 : 16'($urandom); pend = 0;
        end else if (r < rate) begin
          wr_valid = 1; wr_data = 16'h0123; pend = 1;
        end else if (r == 99) begin
          wr_valid = 1; wr_data = 16'($urandom);
        end
        if ($urandom % 100 < 3) flag_clr = 2'($urandom);
        if ($urandom % 100 == 0) sleep_in = !sleep_in;
        @(negedge clk);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule